// File: doc/BRIEF.md
# Device-ID Tree Search Controller

This block finds the 64-bit identifiers of the devices that share a single-wire open-drain bus. Each pass finds one identifier. The bus is wired-AND, so the block walks a binary tree over the identifier bits. It does not time the bus itself. It sends each bus operation, either a bus reset or one time slot, to a separate slot engine over a request/done handshake, and it reads back the level that the engine sampled.

To start a pass, the caller pulses `start` together with two values: the discrepancy position returned by the previous pass (0xFF to begin a new search) and the identifier that pass found. When the pass ends, `search_done` pulses for one cycle. At that point `found_id` holds the new identifier and `result_code` holds one of three things:
- 0xFF when no device answered the reset,
- 0xFE when the bus gave an impossible read pair,
- otherwise the discrepancy position to feed into the next pass, where 0x00 means the last device has been found.

The caller repeats passes until the code is 0x00. This block does not check the trailing check byte of the identifier.

The controller has seven states:
- `S_IDLE` waits for `start`.
- `S_RESET` issues the bus reset. It goes to `S_CMD` when a device is present, and to `S_FINISH` when none is.
- `S_CMD` sends the 8 bits of the search command. It then goes to `S_RD_BIT` with the index set to 64.
- `S_RD_BIT` reads the true bit and goes to `S_RD_CMP`.
- `S_RD_CMP` reads the complement bit. It goes to `S_FINISH` on a fault and to `S_WRITE` otherwise.
- `S_WRITE` writes the chosen direction. It goes back to `S_RD_BIT` with the index decreased by one, or to `S_FINISH` after index 1.
- `S_FINISH` raises `search_done` and returns to `S_IDLE`.

Top module: `idtree_search`

## Requirements
- R1: A pass begins with one bus reset (`eng_op`=0). If the engine reports no presence (`eng_rbit`=0 on that reset), the pass ends with `result_code`=0xFF and issues no time slot.
- R2: After a reset with presence, 8 time slots (`eng_op`=1) write the command byte 0xF0, least significant bit first, so the written bits are 0,0,0,0,1,1,1,1.
- R3: The block then handles index values from 64 down to 1. For each index it sends three slots: a read slot writing 1 (true bit), a read slot writing 1 (complement), and a write slot carrying the chosen direction. A complete pass is therefore 8+192=200 slots.
- R4: If the true bit and the complement both read 1, the pass ends at once with `result_code`=0xFE. No write slot follows that pair.
- R5: If both read 0 (a conflict), the chosen direction is 1 when either of these holds: the previous discrepancy is greater than the index, or the previous ID bit at this position is 1 and the index differs from the previous discrepancy. Otherwise the chosen direction is 0.
- R6: If exactly one of the pair reads 0, the chosen direction equals the true bit, and no discrepancy is recorded.
- R7: The next discrepancy starts each pass at 0x00. It is set to the index of every conflict where 1 is chosen, so the lowest such index remains. On a successful pass, `result_code` equals this value. A previous discrepancy of 0xFF therefore chooses 1 at every conflict.
- R8: The direction chosen at index i is stored in `found_id` bit 64-i. Byte n occupies bits 8n+7..8n and is filled least significant bit first.
- R9: `search_done` is a one-cycle strobe with no request active in that cycle. `result_code` and `found_id` then hold until the next accepted `start`.
- R10: `eng_req` stays high, with `eng_op` and `eng_wbit` stable, until `eng_done`. Each `eng_done` completes exactly one operation.
- R11: A `start` that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted in idle only) |
| prev_disc | input | 8 | Discrepancy from the previous pass, 0xFF for a new search |
| prev_id | input | 64 | Identifier found by the previous pass |
| eng_req | output | 1 | Operation request to the slot engine |
| eng_op | output | 1 | 0 = bus reset, 1 = time slot |
| eng_wbit | output | 1 | Bit driven in a time slot (1 releases the bus, used for reads) |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_rbit | input | 1 | Reset: 1 = presence seen; slot: sampled bus level |
| search_done | output | 1 | One-cycle end-of-pass strobe |
| found_id | output | 64 | Identifier assembled in this pass |
| result_code | output | 8 | 0xFF no presence, 0xFE data error, else next discrepancy (0x00 = last) |

## Verification
On every cycle, the assertions check the following:
- the request/done handshake holds its operation stable;
- the end strobe lasts one cycle, with no request active;
- a failed presence leads directly to the 0xFF code;
- the results hold while idle;
- a successful code is never above 64.

Some behaviours only the bench scenarios can show. These are:
- the tree walk itself: the branch rule at conflicts, the bit placement in the identifier, enumeration of every device on a wired-AND bus model, and the exact slot counts for the command byte and the three-slot groups;
- the fault abort without a write slot;
- a `start` ignored while a pass is running.

// File: rtl/idtree_pkg.sv
package idtree_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_NO_PRESENCE = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_DATA_FAULT  = 8'hFE;
    localparam logic [CODE_W-1:0] CODE_LAST_FOUND  = 8'h00;

    localparam logic OP_BUS_RESET = 1'b0;
    localparam logic OP_TIME_SLOT = 1'b1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET,
        S_CMD,
        S_RD_BIT,
        S_RD_CMP,
        S_WRITE,
        S_FINISH
    } state_t;

    typedef enum logic [1:0] {
        RES_DISC,
        RES_NOPRES,
        RES_FAULT
    } res_kind_t;

endpackage

// File: rtl/idtree_branch.sv
module idtree_branch
    import idtree_pkg::*;
#(
    parameter int ID_BITS = 64,
    localparam int IDX_W = $clog2(ID_BITS + 1)
) (
    input  logic              bit_true,
    input  logic              bit_cmp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CODE_W-1:0] prev_disc,
    input  logic              prev_bit,
    output logic              dir,
    output logic              fault,
    output logic              take_one
);

    logic [CODE_W-1:0] idx_wide;
    logic              conflict;
    logic              past_mark;
    logic              follow_old;

    always_comb begin
        idx_wide   = CODE_W'(idx);
        fault      = bit_true & bit_cmp;
        conflict   = ~bit_true & ~bit_cmp;
        past_mark  = prev_disc > idx_wide;
        follow_old = prev_bit & (prev_disc != idx_wide);
        take_one   = conflict & (past_mark | follow_old);
        dir        = conflict ? take_one : bit_true;
    end

endmodule

// File: rtl/idtree_collect.sv
module idtree_collect
    import idtree_pkg::*;
#(
    parameter int ID_BITS = 64,
    localparam int IDX_W = $clog2(ID_BITS + 1),
    localparam int POS_W = $clog2(ID_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic [CODE_W-1:0]  prev_disc_in,
    input  logic [ID_BITS-1:0] prev_id_in,
    input  logic [IDX_W-1:0]   idx,
    input  logic               shift_en,
    input  logic               dir_in,
    input  logic               mark_en,
    input  logic               res_load,
    input  res_kind_t          res_kind,
    output logic [CODE_W-1:0]  prev_disc_q,
    output logic               prev_bit,
    output logic [ID_BITS-1:0] found_id,
    output logic [CODE_W-1:0]  result_code
);

    localparam logic [IDX_W-1:0] ID_TOP = IDX_W'(ID_BITS);

    logic [ID_BITS-1:0] prev_id_q;
    logic [CODE_W-1:0]  next_disc_q;
    logic [IDX_W-1:0]   pos;
    logic [POS_W-1:0]   pos_lo;
    logic [CODE_W-1:0]  code_val;

    always_comb begin
        pos      = ID_TOP - idx;
        pos_lo   = pos[POS_W-1:0];
        prev_bit = prev_id_q[pos_lo];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_id_q   <= '0;
            prev_disc_q <= '0;
        end else if (clear_all) begin
            prev_id_q   <= prev_id_in;
            prev_disc_q <= prev_disc_in;
        end
    end

    for (genvar g = 0; g < ID_BITS; g++) begin : g_idbit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                found_id[g] <= 1'b0;
            end else if (clear_all) begin
                found_id[g] <= 1'b0;
            end else if (shift_en && (pos == IDX_W'(g))) begin
                found_id[g] <= dir_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_disc_q <= CODE_LAST_FOUND;
        end else if (clear_all) begin
            next_disc_q <= CODE_LAST_FOUND;
        end else if (mark_en) begin
            next_disc_q <= CODE_W'(idx);
        end
    end

    always_comb begin
        unique case (res_kind)
            RES_NOPRES: code_val = CODE_NO_PRESENCE;
            RES_FAULT:  code_val = CODE_DATA_FAULT;
            default:    code_val = next_disc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_code <= CODE_LAST_FOUND;
        end else if (clear_all) begin
            result_code <= CODE_LAST_FOUND;
        end else if (res_load) begin
            result_code <= code_val;
        end
    end

endmodule

// File: rtl/idtree_fsm.sv
module idtree_fsm
    import idtree_pkg::*;
#(
    parameter int          ID_BITS  = 64,
    parameter logic [7:0]  CMD_BYTE = 8'hF0,
    localparam int IDX_W = $clog2(ID_BITS + 1),
    localparam int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             eng_done,
    input  logic             eng_rbit,
    input  logic             dir,
    input  logic             fault,
    input  logic             take_one,
    output logic             eng_req,
    output logic             eng_op,
    output logic             eng_wbit,
    output logic             search_done,
    output logic [IDX_W-1:0] idx,
    output logic             rd_bit_q,
    output logic             dir_q,
    output logic             clear_all,
    output logic             shift_en,
    output logic             mark_en,
    output logic             res_load,
    output res_kind_t        res_kind
);

    localparam logic [IDX_W-1:0] ID_TOP  = IDX_W'(ID_BITS);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(1);
    localparam logic [CNT_W-1:0] CNT_END = '1;

    state_t           state, state_n;
    logic [CNT_W-1:0] cmd_cnt;
    logic             last_idx;

    assign last_idx = (idx == IDX_END);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start)    state_n = S_RESET;
            S_RESET:  if (eng_done) state_n = eng_rbit ? S_CMD : S_FINISH;
            S_CMD:    if (eng_done && (cmd_cnt == CNT_END)) state_n = S_RD_BIT;
            S_RD_BIT: if (eng_done) state_n = S_RD_CMP;
            S_RD_CMP: if (eng_done) state_n = fault ? S_FINISH : S_WRITE;
            S_WRITE:  if (eng_done) state_n = last_idx ? S_FINISH : S_RD_BIT;
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_cnt  <= '0;
            idx      <= '0;
            rd_bit_q <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            if (state == S_RESET) cmd_cnt <= '0;
            else if (state == S_CMD && eng_done) cmd_cnt <= cmd_cnt + 1'b1;

            if (state == S_CMD && eng_done && cmd_cnt == CNT_END) idx <= ID_TOP;
            else if (state == S_WRITE && eng_done) idx <= idx - 1'b1;

            if (state == S_RD_BIT && eng_done) rd_bit_q <= eng_rbit;
            if (state == S_RD_CMP && eng_done) dir_q    <= dir;
        end
    end

    // outputs
    always_comb begin
        eng_req     = 1'b0;
        eng_op      = OP_TIME_SLOT;
        eng_wbit    = 1'b0;
        search_done = 1'b0;
        clear_all   = 1'b0;
        shift_en    = 1'b0;
        mark_en     = 1'b0;
        res_load    = 1'b0;
        res_kind    = RES_DISC;
        unique case (state)
            S_IDLE: begin
                clear_all = start;
            end
            S_RESET: begin
                eng_req = 1'b1;
                eng_op  = OP_BUS_RESET;
                if (eng_done && !eng_rbit) begin
                    res_load = 1'b1;
                    res_kind = RES_NOPRES;
                end
            end
            S_CMD: begin
                eng_req  = 1'b1;
                eng_wbit = CMD_BYTE[cmd_cnt];
            end
            S_RD_BIT: begin
                eng_req  = 1'b1;
                eng_wbit = 1'b1;
            end
            S_RD_CMP: begin
                eng_req  = 1'b1;
                eng_wbit = 1'b1;
                mark_en  = eng_done & take_one;
                if (eng_done && fault) begin
                    res_load = 1'b1;
                    res_kind = RES_FAULT;
                end
            end
            S_WRITE: begin
                eng_req  = 1'b1;
                eng_wbit = dir_q;
                shift_en = eng_done;
                res_load = eng_done & last_idx;
            end
            S_FINISH: begin
                search_done = 1'b1;
            end
            default: begin
                eng_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idtree_search.sv
module idtree_search
    import idtree_pkg::*;
#(
    parameter int         ID_BITS  = 64,
    parameter logic [7:0] CMD_BYTE = 8'hF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         prev_disc,
    input  logic [ID_BITS-1:0] prev_id,
    output logic               eng_req,
    output logic               eng_op,
    output logic               eng_wbit,
    input  logic               eng_done,
    input  logic               eng_rbit,
    output logic               search_done,
    output logic [ID_BITS-1:0] found_id,
    output logic [7:0]         result_code
);

    localparam int IDX_W = $clog2(ID_BITS + 1);

    logic [IDX_W-1:0]  idx;
    logic              rd_bit_q, dir_q, dir, fault, take_one;
    logic              clear_all, shift_en, mark_en, res_load;
    res_kind_t         res_kind;
    logic [CODE_W-1:0] prev_disc_q;
    logic              prev_bit;

    idtree_fsm #(.ID_BITS(ID_BITS), .CMD_BYTE(CMD_BYTE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .eng_done(eng_done), .eng_rbit(eng_rbit),
        .dir(dir), .fault(fault), .take_one(take_one),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbit(eng_wbit),
        .search_done(search_done), .idx(idx),
        .rd_bit_q(rd_bit_q), .dir_q(dir_q),
        .clear_all(clear_all), .shift_en(shift_en), .mark_en(mark_en),
        .res_load(res_load), .res_kind(res_kind)
    );

    idtree_branch #(.ID_BITS(ID_BITS)) u_branch (
        .bit_true(rd_bit_q), .bit_cmp(eng_rbit), .idx(idx),
        .prev_disc(prev_disc_q), .prev_bit(prev_bit),
        .dir(dir), .fault(fault), .take_one(take_one)
    );

    idtree_collect #(.ID_BITS(ID_BITS)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
        .prev_disc_in(prev_disc), .prev_id_in(prev_id), .idx(idx),
        .shift_en(shift_en), .dir_in(dir_q), .mark_en(mark_en),
        .res_load(res_load), .res_kind(res_kind),
        .prev_disc_q(prev_disc_q), .prev_bit(prev_bit),
        .found_id(found_id), .result_code(result_code)
    );

endmodule

// File: rtl/idtree_search_chk.sv
module idtree_search_chk #(
    parameter int ID_BITS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               eng_req,
    input logic               eng_op,
    input logic               eng_wbit,
    input logic               eng_done,
    input logic               eng_rbit,
    input logic               search_done,
    input logic [ID_BITS-1:0] found_id,
    input logic [7:0]         result_code
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wbit)));

    assert_done_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        search_done |=> !search_done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        search_done |-> !eng_req);

    assert_no_presence_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 1'b0 && eng_done && !eng_rbit)
        |=> (search_done && result_code == 8'hFF));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_req && !search_done && !start)
        |=> ($stable(result_code) && $stable(found_id)));

    assert_disc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (search_done && result_code != 8'hFF && result_code != 8'hFE)
        |-> (result_code <= 8'(ID_BITS)));

endmodule

bind idtree_search idtree_search_chk #(.ID_BITS(ID_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbit(eng_wbit),
    .eng_done(eng_done), .eng_rbit(eng_rbit),
    .search_done(search_done), .found_id(found_id), .result_code(result_code)
);

// File: tb/idtree_search_bench.sv
module idtree_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  prev_disc = 8'h00;
    logic [63:0] prev_id = '0;
    logic        eng_req, eng_op, eng_wbit;
    logic        eng_done = 1'b0;
    logic        eng_rbit = 1'b0;
    logic        search_done;
    logic [63:0] found_id;
    logic [7:0]  result_code;

    always #4 clk = ~clk;

    idtree_search u_idtree_search (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prev_disc(prev_disc), .prev_id(prev_id),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbit(eng_wbit),
        .eng_done(eng_done), .eng_rbit(eng_rbit),
        .search_done(search_done), .found_id(found_id), .result_code(result_code)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bus model
    logic [63:0] dev [8];
    int          ndev = 0;
    logic [7:0]  active;
    int          slot_no = 0;
    int          n_resets = 0;
    int          cmd_bad = 0;
    int          hold_bad = 0;
    int          fault_pos = -1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic and_true(input int pos);
        logic r = 1'b1;
        for (int d = 0; d < ndev; d++) if (active[d]) r &= dev[d][pos];
        return r;
    endfunction

    function automatic logic and_cmp(input int pos);
        logic r = 1'b1;
        for (int d = 0; d < ndev; d++) if (active[d]) r &= ~dev[d][pos];
        return r;
    endfunction

    // slot engine model on a wired-AND bus
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                logic op0, w0;
                int dly;
                op0 = eng_op;
                w0  = eng_wbit;
                dly = $urandom_range(0, 3);
                repeat (dly) begin
                    @(negedge clk);
                    if (!eng_req || eng_op != op0 || eng_wbit != w0) hold_bad++;
                end
                if (op0 == 1'b0) begin
                    n_resets++;
                    slot_no = 0;
                    active = '0;
                    for (int d = 0; d < ndev; d++) active[d] = 1'b1;
                    eng_rbit = (ndev > 0);
                end else begin
                    if (slot_no < 8) begin
                        if (w0 != ((8'hF0 >> slot_no) & 1)) cmd_bad++;
                        eng_rbit = w0;
                    end else begin
                        int t, pos, ph;
                        t = slot_no - 8; pos = t / 3; ph = t % 3;
                        if (ph == 0)      eng_rbit = and_true(pos) | (pos == fault_pos);
                        else if (ph == 1) eng_rbit = and_cmp(pos)  | (pos == fault_pos);
                        else begin
                            for (int d = 0; d < ndev; d++)
                                if (dev[d][pos] != w0) active[d] = 1'b0;
                            eng_rbit = w0;
                        end
                    end
                    slot_no++;
                end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    // expected pass result from the requirements
    function automatic logic [71:0] ref_pass(input logic [7:0] diff, input logic [63:0] prv);
        logic [7:0]  act, nd;
        logic [63:0] id;
        logic        b, c, ch;
        int          i;
        if (ndev == 0) return {8'hFF, 64'h0};
        act = '0; nd = 8'h00; id = '0;
        for (int d = 0; d < ndev; d++) act[d] = 1'b1;
        for (int k = 0; k < 64; k++) begin
            i = 64 - k;
            b = 1'b1; c = 1'b1;
            for (int d = 0; d < ndev; d++) if (act[d]) begin b &= dev[d][k]; c &= ~dev[d][k]; end
            if (k == fault_pos) begin b = 1'b1; c = 1'b1; end
            if (b && c) return {8'hFE, id};
            if (!b && !c) begin
                ch = (int'(diff) > i) || (prv[k] && int'(diff) != i);
                if (ch) nd = 8'(i);
            end else ch = b;
            id[k] = ch;
            for (int d = 0; d < ndev; d++) if (dev[d][k] != ch) act[d] = 1'b0;
        end
        return {nd, id};
    endfunction

    task automatic run_pass(input logic [7:0] d, input logic [63:0] p, input bit poke,
                            output logic [7:0] code, output logic [63:0] id);
        int guard;
        n_resets = 0; cmd_bad = 0; hold_bad = 0;
        @(negedge clk);
        prev_disc = d; prev_id = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            prev_disc = 8'h00; prev_id = ~p; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!search_done && guard < 5000) begin @(negedge clk); guard++; end
        code = result_code; id = found_id;
        @(negedge clk);
        chk(!search_done, "R9 strobe one cycle", 64'(search_done), 64'h0);
        chk(result_code == code && found_id == id, "R9 result hold", 64'(result_code), 64'(code));
        chk(hold_bad == 0, "R10 request held stable", 64'(hold_bad), 64'h0);
    endtask

    task automatic compare_ref(input logic [7:0] d, input logic [63:0] p, input string tag,
                               output logic [7:0] code, output logic [63:0] id);
        logic [71:0] e;
        e = ref_pass(d, p);
        run_pass(d, p, 1'b0, code, id);
        chk(code == e[71:64], {tag, " code"}, 64'(code), 64'(e[71:64]));
        chk(id == e[63:0], {tag, " id"}, id, e[63:0]);
    endtask

    task automatic enumerate(input string tag);
        logic [7:0]  d, code;
        logic [63:0] p, id;
        logic [7:0]  seen;
        int          passes;
        d = 8'hFF; p = '0; seen = '0; passes = 0;
        do begin
            compare_ref(d, p, {tag, " R5 R7 R8"}, code, id);
            for (int k = 0; k < ndev; k++) if (dev[k] == id) seen[k] = 1'b1;
            d = code; p = id; passes++;
        end while (code != 8'h00 && code != 8'hFE && code != 8'hFF && passes < 12);
        chk(passes == ndev, {tag, " R7 pass count"}, 64'(passes), 64'(ndev));
        chk($countones(seen) == ndev, {tag, " R7 all devices found"}, 64'(seen), 64'(ndev));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired actual=%h expected=%h", 64'h1, 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  code;
        logic [63:0] id;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!eng_req && !search_done, "R9 idle after reset", {62'h0, eng_req, search_done}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // no device
        ndev = 0;
        run_pass(8'hFF, '0, 1'b0, code, id);
        chk(code == 8'hFF, "R1 no presence code", 64'(code), 64'hFF);
        chk(slot_no == 0 && n_resets == 1, "R1 no slots after failed reset", 64'(slot_no), 64'h0);

        // one device
        ndev = 1; dev[0] = {$urandom, $urandom};
        run_pass(8'hFF, '0, 1'b0, code, id);
        chk(id == dev[0], "R8 R6 single device id", id, dev[0]);
        chk(code == 8'h00, "R6 single device last", 64'(code), 64'h0);
        chk(cmd_bad == 0, "R2 command byte bits", 64'(cmd_bad), 64'h0);
        chk(slot_no == 200, "R3 slot count", 64'(slot_no), 64'd200);

        // conflict at index 64
        ndev = 2; dev[0] = 64'h0; dev[1] = 64'h8000_0000_0000_0001;
        run_pass(8'hFF, '0, 1'b0, code, id);
        chk(code == 8'd64, "R7 discrepancy at index 64", 64'(code), 64'd64);
        chk(id == dev[1], "R5 first branch one", id, dev[1]);
        run_pass(code, id, 1'b0, code, id);
        chk(code == 8'h00 && id == dev[0], "R5 second branch zero", id, dev[0]);

        // conflict at index 1
        dev[0] = 64'h0123_4567_89AB_CDEF; dev[1] = dev[0] | 64'h8000_0000_0000_0000;
        run_pass(8'hFF, '0, 1'b0, code, id);
        chk(code == 8'd1, "R7 discrepancy at index 1", 64'(code), 64'd1);
        chk(id == dev[1], "R8 top bit placement", id, dev[1]);
        enumerate("pair-top");

        // random device sets
        for (int r = 0; r < 4; r++) begin
            ndev = 2 + $urandom_range(0, 5);
            for (int k = 0; k < ndev; k++) dev[k] = {$urandom, $urandom};
            if (r == 0) begin
                dev[1] = dev[0] ^ 64'h0000_0000_0001_0000;
                dev[2] = dev[0] ^ 64'h0000_0000_0003_0000;
            end
            enumerate("random set");
        end

        // continuation from a last-device state
        compare_ref(8'h00, dev[0], "R5 zero previous discrepancy", code, id);

        // fault injection
        ndev = 2; dev[0] = {$urandom, $urandom}; dev[1] = ~dev[0];
        fault_pos = 10;
        run_pass(8'hFF, '0, 1'b0, code, id);
        chk(code == 8'hFE, "R4 data error code", 64'(code), 64'hFE);
        chk(slot_no == 8 + 3 * 10 + 2, "R4 no write slot after fault", 64'(slot_no), 64'd40);
        fault_pos = -1;

        // start while busy
        ndev = 3;
        for (int k = 0; k < ndev; k++) dev[k] = {$urandom, $urandom};
        begin
            logic [71:0] e;
            e = ref_pass(8'hFF, '0);
            run_pass(8'hFF, '0, 1'b1, code, id);
            chk(n_resets == 1, "R11 one reset despite second start", 64'(n_resets), 64'h1);
            chk(code == e[71:64] && id == e[63:0], "R11 result unaffected", id, e[63:0]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule